// File: doc/BRIEF.md
# Multi-Source Reset Controller with Sticky Cause Register

This block gathers every reset request in a small system and turns them into separate active-low reset outputs: one for the processor core, one for the full JTAG logic, one for the JTAG pin-configuration logic, and one for each on-chip peripheral. Each request source carries its own mask that selects which of these domains it resets. A power-on reset clears all domains, JTAG included. The external reset pin, the two watchdog requests, the two hibernation requests, the service-request reset and the main-oscillator failure flag reset the core, the pin configuration and all peripherals. They never reset the full JTAG logic. Software can reset single peripherals through a register without touching the core.

Asynchronous requests pass through two-flop synchronisers. Every output is stretched so that it stays asserted for a fixed number of cycles after its last request goes away. A cause register records which sources started a reset. Its bits survive later resets and are cleared only when software writes zero to them. Both registers sit on a minimal single-cycle register bus.

Top module: `rst_merge_ctrl`

## Requirements
- R1: While `por_n` is low, every reset output is low and the cause register reads 0x01. After `por_n` rises, all outputs are released on the 17th rising clock edge, which is HOLD_CYCLES+1.
- R2: `jtag_rst_n` is driven low only by `por_n`. No other source or register write ever lowers it.
- R3: Raising any hardware source lowers `core_rst_n`, `pincfg_rst_n` and every bit of `periph_rst_n` on the third rising edge after the change. The edges before that leave the outputs high.
- R4: When the last request is removed, the outputs stay low for another HOLD_CYCLES+2 rising edges and rise on the HOLD_CYCLES+3rd edge.
- R5: Writing 1 to bit i of the software peripheral reset register at address 0x500 lowers only `periph_rst_n[i]`, one edge after the write edge. The core, the pin configuration and the other peripherals stay out of reset.
- R6: Cause bit positions are: 0 power-on, 1 external pin, 2 watchdog power-on, 3 watchdog system, 4 hibernation power-on, 5 hibernation system, 6 service request, 7 oscillator failure. A bit is set in the same edge as its reset asserts. If several sources rise together, all of their bits are set.
- R7: Cause bits stay set across later non-power-on resets. A power-on reset leaves only bit 0 set.
- R8: A bus write to the cause register at address 0x05C clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R9: If the external pin is held low while `por_n` releases, the core stays in reset until the pin rises. The cause register then shows both bit 0 and bit 1.
- R10: Bus reads return the cause register in bits 7:0 and the software reset register in bits NUM_PERIPH-1:0. Any other address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_por_req | input | 1 | Watchdog power-on style request |
| wdog_sys_req | input | 1 | Watchdog system style request |
| hib_por_req | input | 1 | Hibernation power-on style request |
| hib_sys_req | input | 1 | Hibernation system style request |
| srv_req | input | 1 | Service-request reset |
| mosc_fail | input | 1 | Main oscillator failure flag |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| core_rst_n | output | 1 | Core reset, active low |
| jtag_rst_n | output | 1 | Full JTAG reset, active low |
| pincfg_rst_n | output | 1 | Pin-configuration reset, active low |
| periph_rst_n | output | NUM_PERIPH | Per-peripheral resets, active low |

## Verification
The assertions check on every cycle that the full JTAG reset never falls outside power-on reset, and that a core reset always coincides with pin-configuration and peripheral resets. They also check that cause bits only disappear under a bus write, that a falling core reset always leaves a cause bit behind, and that the core is never released before HOLD_CYCLES quiet cycles. The bench alone shows the exact latency of each source, the separate effect of each software reset bit, the cause pattern for every pair of simultaneous sources, the write-zero clearing rule, and the external pin holding the device across a power-on release.

// File: rtl/rmc_pkg.sv
// Shared definitions for the reset controller: source indices and the
// per-source domain masks. Assumes the cause register is one bit per source.
package rmc_pkg;

    localparam int NUM_SRC = 8;

    typedef enum logic [2:0] {
        SRC_POR      = 3'd0,
        SRC_EXT      = 3'd1,
        SRC_WDOG_POR = 3'd2,
        SRC_WDOG_SYS = 3'd3,
        SRC_HIB_POR  = 3'd4,
        SRC_HIB_SYS  = 3'd5,
        SRC_SRV      = 3'd6,
        SRC_MOSC     = 3'd7
    } src_e;

    typedef struct packed {
        logic core;
        logic pincfg;
        logic periph;
    } dom_mask_t;

    // Domain mask per source; every non-power-on source hits core, pins, peripherals.
    function automatic dom_mask_t src_mask(input int idx);
        dom_mask_t m;
        m.core   = 1'b1;
        m.pincfg = 1'b1;
        m.periph = 1'b1;
        if (idx < 0 || idx >= NUM_SRC) m = '0;
        return m;
    endfunction

endpackage

// File: rtl/rmc_sync.sv
// Two-flop synchroniser bank for asynchronous reset requests.
// Assumes requests are active high. Cleared by power-on reset.
module rmc_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two-stage capture of the raw request lines.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/rmc_stretch.sv
// Reset stretcher: drives rst_n_o low while req is high and for HOLD more
// edges after it falls. Assumes req is already synchronous to clk.
module rmc_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic req,
    output logic rst_n_o
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_q;

    // Reload on request, count down once quiet, release at zero.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cnt_q   <= CW'(HOLD);
            rst_n_o <= 1'b0;
        end else if (req) begin
            cnt_q   <= CW'(HOLD);
            rst_n_o <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q   <= cnt_q - 1'b1;
            rst_n_o <= 1'b0;
        end else begin
            rst_n_o <= 1'b1;
        end
    end
endmodule

// File: rtl/rmc_regs.sv
// Register file: sticky cause register (write-0-to-clear, set on source rise)
// and the software peripheral reset register. Only power-on reset clears them.
module rmc_regs #(
    parameter int          NP         = 4,
    parameter int          AW         = 12,
    parameter int          NS         = 8,
    parameter logic [AW-1:0] CAUSE_ADDR = 12'h05C,
    parameter logic [AW-1:0] SWRST_ADDR = 12'h500
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    input  logic [NS-1:0] src_rise,
    output logic [31:0]   bus_rdata,
    output logic [NS-1:0] cause_q,
    output logic [NP-1:0] sw_rst_q,
    output logic          cause_wr
);
    logic sw_wr;

    assign cause_wr = bus_sel && bus_wr && (bus_addr == CAUSE_ADDR);
    assign sw_wr    = bus_sel && bus_wr && (bus_addr == SWRST_ADDR);

    // Cause bits: new events set, zero writes clear, set wins.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cause_q <= NS'(1);
        end else begin
            cause_q <= (cause_wr ? (cause_q & bus_wdata[NS-1:0]) : cause_q) | src_rise;
        end
    end

    // Software peripheral reset bits, plain read/write.
    always_ff @(posedge clk) begin
        if (!por_n)     sw_rst_q <= '0;
        else if (sw_wr) sw_rst_q <= bus_wdata[NP-1:0];
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == CAUSE_ADDR)      bus_rdata[NS-1:0] = cause_q;
            else if (bus_addr == SWRST_ADDR) bus_rdata[NP-1:0] = sw_rst_q;
        end
    end
endmodule

// File: rtl/rst_merge_ctrl.sv
// Top of the reset controller. Synchronises hardware requests, applies the
// per-source domain masks, stretches each domain reset and keeps the cause
// register. por_n is the synchronous active-low reset of this block itself.
module rst_merge_ctrl #(
    parameter int              NUM_PERIPH  = 4,
    parameter int              HOLD_CYCLES = 16,
    parameter int              ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] CAUSE_ADDR  = 12'h05C,
    parameter logic [ADDR_W-1:0] SWRST_ADDR  = 12'h500
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  ext_rst_n,
    input  logic                  wdog_por_req,
    input  logic                  wdog_sys_req,
    input  logic                  hib_por_req,
    input  logic                  hib_sys_req,
    input  logic                  srv_req,
    input  logic                  mosc_fail,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  core_rst_n,
    output logic                  jtag_rst_n,
    output logic                  pincfg_rst_n,
    output logic [NUM_PERIPH-1:0] periph_rst_n
);
    import rmc_pkg::*;

    localparam int NHW = NUM_SRC - 1;

    logic [NHW-1:0]     raw_req, syn_req, syn_d;
    logic [NUM_SRC-1:0] src_rise, cause_q;
    logic [NUM_PERIPH-1:0] sw_rst_q;
    logic core_req, pin_req, per_req, cause_wr;

    // Hardware requests in cause-bit order, index 0 = cause bit 1.
    assign raw_req = {mosc_fail, srv_req, hib_sys_req, hib_por_req,
                      wdog_sys_req, wdog_por_req, ~ext_rst_n};

    rmc_sync #(.W(NHW)) u_sync (
        .clk(clk), .por_n(por_n), .d(raw_req), .q(syn_req)
    );

    // Previous synchronised value for rise detection.
    always_ff @(posedge clk) begin
        if (!por_n) syn_d <= '0;
        else        syn_d <= syn_req;
    end

    assign src_rise = {syn_req & ~syn_d, 1'b0};

    // Merge the sources into domain requests through each source's mask.
    always_comb begin
        dom_mask_t m;
        core_req = 1'b0;
        pin_req  = 1'b0;
        per_req  = 1'b0;
        for (int s = 1; s < NUM_SRC; s++) begin
            m = src_mask(s);
            core_req = core_req | (syn_req[s-1] & m.core);
            pin_req  = pin_req  | (syn_req[s-1] & m.pincfg);
            per_req  = per_req  | (syn_req[s-1] & m.periph);
        end
    end

    rmc_stretch #(.HOLD(HOLD_CYCLES)) u_core (
        .clk(clk), .por_n(por_n), .req(core_req), .rst_n_o(core_rst_n)
    );
    rmc_stretch #(.HOLD(HOLD_CYCLES)) u_pin (
        .clk(clk), .por_n(por_n), .req(pin_req), .rst_n_o(pincfg_rst_n)
    );
    rmc_stretch #(.HOLD(HOLD_CYCLES)) u_jtag (
        .clk(clk), .por_n(por_n), .req(1'b0), .rst_n_o(jtag_rst_n)
    );

    generate
        for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_per
            rmc_stretch #(.HOLD(HOLD_CYCLES)) u_per (
                .clk(clk), .por_n(por_n), .req(per_req | sw_rst_q[p]),
                .rst_n_o(periph_rst_n[p])
            );
        end
    endgenerate

    rmc_regs #(
        .NP(NUM_PERIPH), .AW(ADDR_W), .NS(NUM_SRC),
        .CAUSE_ADDR(CAUSE_ADDR), .SWRST_ADDR(SWRST_ADDR)
    ) u_regs (
        .clk(clk), .por_n(por_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .src_rise(src_rise),
        .bus_rdata(bus_rdata), .cause_q(cause_q), .sw_rst_q(sw_rst_q),
        .cause_wr(cause_wr)
    );
endmodule

// File: rtl/rst_merge_ctrl_chk.sv
// Property checker for rst_merge_ctrl, attached by bind. Tracks quiet cycles
// of the core request itself so the hold window needs no deep $past.
module rst_merge_ctrl_chk #(
    parameter int NP   = 4,
    parameter int HOLD = 16
) (
    input logic          clk,
    input logic          por_n,
    input logic          core_req,
    input logic          core_rst_n,
    input logic          jtag_rst_n,
    input logic          pincfg_rst_n,
    input logic [NP-1:0] periph_rst_n,
    input logic [7:0]    cause_q,
    input logic          cause_wr
);
    localparam int CW = $clog2(HOLD + 2);

    logic [CW-1:0] quiet_q;

    // Count cycles with no core request, saturating at HOLD.
    always_ff @(posedge clk) begin
        if (!por_n || core_req)       quiet_q <= '0;
        else if (quiet_q < CW'(HOLD)) quiet_q <= quiet_q + 1'b1;
    end

    assert_jtag_por_only_R2: assert property (@(posedge clk) disable iff (!por_n)
        jtag_rst_n |=> jtag_rst_n);

    assert_core_implies_pins_R3: assert property (@(posedge clk) disable iff (!por_n)
        !core_rst_n |-> !pincfg_rst_n);

    assert_core_implies_periph_R3: assert property (@(posedge clk) disable iff (!por_n)
        !core_rst_n |-> (periph_rst_n == '0));

    assert_hold_window_R4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst_n) |-> (quiet_q >= CW'(HOLD)));

    assert_cause_on_reset_R6: assert property (@(posedge clk) disable iff (!por_n)
        $fell(core_rst_n) |-> (cause_q[7:1] != '0));

    assert_cause_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        !cause_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

bind rst_merge_ctrl rst_merge_ctrl_chk #(.NP(NUM_PERIPH), .HOLD(HOLD_CYCLES)) u_chk (
    .clk(clk), .por_n(por_n), .core_req(core_req), .core_rst_n(core_rst_n),
    .jtag_rst_n(jtag_rst_n), .pincfg_rst_n(pincfg_rst_n),
    .periph_rst_n(periph_rst_n), .cause_q(cause_q), .cause_wr(cause_wr)
);

// File: tb/rst_merge_ctrl_test.sv
module rst_merge_ctrl_test;
    localparam int NP   = 4;
    localparam int HOLD = 16;
    localparam logic [11:0] A_CAUSE = 12'h05C;
    localparam logic [11:0] A_SWRST = 12'h500;
    localparam logic [6:0]  ALL_HI  = 7'h7F;
    localparam logic [6:0]  HW_RST  = 7'b0010000;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic [7:1] req = '0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic core_rst_n, jtag_rst_n, pincfg_rst_n;
    logic [NP-1:0] periph_rst_n;
    int checks = 0, fails = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    rst_merge_ctrl #(.NUM_PERIPH(NP), .HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .por_n(por_n), .ext_rst_n(~req[1]),
        .wdog_por_req(req[2]), .wdog_sys_req(req[3]), .hib_por_req(req[4]),
        .hib_sys_req(req[5]), .srv_req(req[6]), .mosc_fail(req[7]),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_rst_n(core_rst_n), .jtag_rst_n(jtag_rst_n),
        .pincfg_rst_n(pincfg_rst_n), .periph_rst_n(periph_rst_n)
    );

    // Outputs packed as {core, pincfg, jtag, periph[3:0]}.
    function automatic logic [6:0] outs();
        return {core_rst_n, pincfg_rst_n, jtag_rst_n, periph_rst_n};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Apply a request mask, check onset latency, then check hold and release.
    task automatic pulse(input logic [7:1] m);
        @(negedge clk) req = m;
        repeat (2) @(posedge clk);
        @(negedge clk) chk("R3 before onset", 32'(outs()), 32'(ALL_HI));
        @(posedge clk);
        @(negedge clk) chk("R3 onset", 32'(outs()), 32'(HW_RST));
        chk("R2 jtag untouched", 32'(jtag_rst_n), 32'd1);
        repeat (3) @(posedge clk);
        @(negedge clk) req = '0;
        repeat (HOLD + 2) @(posedge clk);
        @(negedge clk) chk("R4 still held", 32'(outs()), 32'(HW_RST));
        @(posedge clk);
        @(negedge clk) chk("R4 released", 32'(outs()), 32'(ALL_HI));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        // R1: power-on state.
        repeat (3) @(posedge clk);
        @(negedge clk) chk("R1 outputs in por", 32'(outs()), 32'h0);
        bus_read(A_CAUSE, rd); chk("R1 cause in por", rd, 32'h01);
        @(negedge clk) por_n = 1'b1;
        repeat (HOLD) @(posedge clk);
        @(negedge clk) chk("R1 held after por", 32'(outs()), 32'h0);
        @(posedge clk);
        @(negedge clk) chk("R1 released", 32'(outs()), 32'(ALL_HI));
        bus_read(A_CAUSE, rd); chk("R10 cause read", rd, 32'h01);
        bus_read(12'h123, rd); chk("R10 unmapped read", rd, 32'h0);

        // Each single source: onset, hold, cause bit.
        for (int s = 1; s <= 7; s++) begin
            bus_write(A_CAUSE, 32'h0);
            pulse(7'(1 << (s - 1)));
            bus_read(A_CAUSE, rd); chk("R6 single cause", rd, 32'(1 << s));
        end

        // R8: write-1 keeps, write-0 clears selectively.
        bus_write(A_CAUSE, 32'hFF);
        bus_read(A_CAUSE, rd); chk("R8 write one keeps", rd, 32'h80);
        bus_write(A_CAUSE, 32'h0);
        bus_read(A_CAUSE, rd); chk("R8 write zero clears", rd, 32'h0);

        // R6: every pair of simultaneous sources.
        for (int i = 1; i <= 7; i++) begin
            for (int j = i + 1; j <= 7; j++) begin
                logic [7:1] m;
                m = '0; m[i] = 1'b1; m[j] = 1'b1;
                bus_write(A_CAUSE, 32'h0);
                pulse(m);
                bus_read(A_CAUSE, rd); chk("R6 pair cause", rd, 32'({m, 1'b0}));
            end
        end

        // R7: sticky across a later reset; R8 partial clear.
        bus_write(A_CAUSE, 32'h0);
        pulse(7'b0000010);
        pulse(7'b0000100);
        bus_read(A_CAUSE, rd); chk("R7 sticky", rd, 32'h0C);
        bus_write(A_CAUSE, 32'hF7);
        bus_read(A_CAUSE, rd); chk("R8 partial clear", rd, 32'h04);
        bus_write(A_CAUSE, 32'h0);

        // R5: software reset of each peripheral alone.
        for (int p = 0; p < NP; p++) begin
            bus_write(A_SWRST, 32'(1 << p));
            @(posedge clk);
            @(negedge clk) chk("R5 single periph", 32'(outs()),
                               32'({3'b111, ~NP'(1 << p)}));
            bus_read(A_SWRST, rd); chk("R10 swrst read", rd, 32'(1 << p));
            bus_write(A_SWRST, 32'h0);
            repeat (HOLD + 3) @(posedge clk);
            @(negedge clk) chk("R5 periph released", 32'(outs()), 32'(ALL_HI));
            bus_read(A_CAUSE, rd); chk("R5 no cause", rd, 32'h0);
        end

        // R7 and R9: power-on with external pin held low.
        bus_write(A_CAUSE, 32'h0);
        pulse(7'b1000000);
        @(negedge clk) begin por_n = 1'b0; req[1] = 1'b1; end
        repeat (2) @(posedge clk);
        @(negedge clk) chk("R1 por outputs", 32'(outs()), 32'h0);
        bus_read(A_CAUSE, rd); chk("R7 por resets cause", rd, 32'h01);
        @(negedge clk) por_n = 1'b1;
        repeat (HOLD + 10) @(posedge clk);
        @(negedge clk) chk("R9 core held by pin", 32'(core_rst_n), 32'd0);
        chk("R2 jtag after por", 32'(jtag_rst_n), 32'd1);
        bus_read(A_CAUSE, rd); chk("R9 cause por and pin", rd, 32'h03);
        @(negedge clk) req = '0;
        repeat (HOLD + 2) @(posedge clk);
        @(negedge clk) chk("R9 still held", 32'(core_rst_n), 32'd0);
        @(posedge clk);
        @(negedge clk) chk("R9 released", 32'(outs()), 32'(ALL_HI));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule